// File: doc/BRIEF.md
# Bit-Serial Register Access Engine

This block lets a host reach a small register space through a single data line. The host has two single-cycle strobes. A write strobe carries one bit in. A read strobe asks for one bit back. Every transaction opens with a 4-bit address, least significant bit first. When the address is one of two command codes, the transaction ends at once and a one-cycle command pulse is issued. Any other address opens a data phase of eight bit transfers, least significant bit first. The first transfer of that phase sets its direction.

On the register side, the engine presents an address, a write byte, a write enable and a combinational read byte. Addresses 10 to 13 are outside the register map. They read as zero and never raise the write enable. A read strobe can never begin a transaction, so a burst of eight reads always brings the engine back to waiting for the first address bit. The engine has no timeout and holds its position for as long as the host leaves it idle.

Top module: `bitser_access`

## Requirements
- R1: After reset the engine waits for address bit 0, and `rd_bit_o`, `reg_we_o`, `cmd_load_o`, `cmd_snap_o` and `reg_addr_o` are all zero.
- R2: Four write strobes assemble the address in order bit 0 to bit 3, and the assembled value appears on `reg_addr_o`.
- R3: A read strobe while waiting for an address bit (bit 0 to bit 3) returns 0 on `rd_bit_o`, discards any partial address, and leaves the engine waiting for address bit 0.
- R4: When the fourth address bit completes code 0xE, `cmd_load_o` is high for exactly one cycle, the cycle after that strobe. Code 0xF does the same on `cmd_snap_o`. In both cases the engine then waits for address bit 0.
- R5: Any other address opens a data phase of exactly eight transfers. After the eighth transfer the next write is taken as address bit 0.
- R6: In a read data phase, each read strobe updates `rd_bit_o` in the following cycle with the next bit of `reg_rdata_i`, bit 0 first. `rd_bit_o` only changes after a read strobe.
- R7: In a write data phase, eight writes assemble a byte, bit 0 first. In the cycle after the eighth write, `reg_we_o` is high for one cycle, with that byte on `reg_wdata_o` and the address on `reg_addr_o`.
- R8: Addresses 10 to 13 return 0 for every read bit and never assert `reg_we_o`.
- R9: The first data transfer fixes the direction of the phase. A strobe in the other direction aborts to waiting for address bit 0, and no write is committed.
- R10: Eight consecutive read strobes from any state leave the engine waiting for address bit 0.
- R11: With no strobes the engine keeps its state and outputs indefinitely, and a transaction can resume after any idle gap.
- R12: A cycle with both strobes high is handled as a read strobe alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one bit per cycle |
| wr_bit_i | input | 1 | Bit carried by the write strobe |
| rd_i | input | 1 | Read strobe |
| rd_bit_o | output | 1 | Bit returned by the last read strobe |
| reg_addr_o | output | 4 | Register address |
| reg_wdata_o | output | 8 | Assembled write byte |
| reg_we_o | output | 1 | One-cycle register write enable |
| reg_rdata_i | input | 8 | Read byte for `reg_addr_o` |
| cmd_load_o | output | 1 | Pulse for command code 0xE |
| cmd_snap_o | output | 1 | Pulse for command code 0xF |

## Verification
A bit counter or phase that has slipped out of step misaligns every later field. A stray read position shows up as a wrong bit on `rd_bit_o` in the cycle after that strobe. A stray write position shows up as a wrong byte or a missing `reg_we_o` one cycle after the eighth write. A wrong address decode makes a command pulse appear on the wrong output, or not at all, one cycle after the fourth address bit. Because eight reads must always resynchronise the engine, every partial state is followed by a burst of reads and then a full write and read-back, which exposes any state that fails to recover.

// File: rtl/bitser_pkg.sv
package bitser_pkg;
  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,  // collecting address bits
    PH_DANY = 2'd1,  // address done, direction open
    PH_DRD  = 2'd2,  // read data phase
    PH_DWR  = 2'd3   // write data phase
  } phase_e;
endpackage

// File: rtl/bitser_seq.sv
module bitser_seq
  import bitser_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int CMD_LOAD = 14,
  parameter int CMD_SNAP = 15,
  parameter int CNT_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_nxt_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              addr_shift_o,
  output logic              data_shift_o,
  output logic              rd_take_o,
  output logic              commit_o,
  output logic              cmd_load_o,
  output logic              cmd_snap_o
);
  phase_e ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic commit_q, commit_n, load_q, load_n, snap_q, snap_n;
  logic rd_evt, wr_evt, last_a, last_d;

  assign rd_evt = rd_i;
  assign wr_evt = wr_i & ~rd_i;  // read wins on a collision
  assign last_a = (cnt_q == CNT_W'(ADDR_W-1));
  assign last_d = (cnt_q == CNT_W'(DATA_W-1));

  always_comb begin
    ph_n = ph_q;
    cnt_n = cnt_q;
    addr_shift_o = 1'b0;
    data_shift_o = 1'b0;
    rd_take_o = 1'b0;
    commit_n = 1'b0;
    load_n = 1'b0;
    snap_n = 1'b0;
    unique case (ph_q)
      PH_ADDR: begin
        if (rd_evt) begin
          cnt_n = '0;
        end else if (wr_evt) begin
          addr_shift_o = 1'b1;
          if (last_a) begin
            cnt_n = '0;
            if (addr_nxt_i == ADDR_W'(CMD_LOAD)) load_n = 1'b1;
            else if (addr_nxt_i == ADDR_W'(CMD_SNAP)) snap_n = 1'b1;
            else ph_n = PH_DANY;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
      end
      PH_DANY, PH_DRD: begin
        if (rd_evt) begin
          rd_take_o = 1'b1;
          if (last_d) begin
            ph_n = PH_ADDR;
            cnt_n = '0;
          end else begin
            ph_n = PH_DRD;
            cnt_n = cnt_q + CNT_W'(1);
          end
        end else if (wr_evt) begin
          if (ph_q == PH_DANY) begin
            data_shift_o = 1'b1;
            if (last_d) begin
              commit_n = 1'b1;
              ph_n = PH_ADDR;
              cnt_n = '0;
            end else begin
              ph_n = PH_DWR;
              cnt_n = cnt_q + CNT_W'(1);
            end
          end else begin
            ph_n = PH_ADDR;  // direction clash
            cnt_n = '0;
          end
        end
      end
      PH_DWR: begin
        if (rd_evt) begin
          ph_n = PH_ADDR;
          cnt_n = '0;
        end else if (wr_evt) begin
          data_shift_o = 1'b1;
          if (last_d) begin
            commit_n = 1'b1;
            ph_n = PH_ADDR;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
      end
      default: begin
        ph_n = PH_ADDR;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_ADDR;
      cnt_q <= '0;
      commit_q <= 1'b0;
      load_q <= 1'b0;
      snap_q <= 1'b0;
    end else begin
      ph_q <= ph_n;
      cnt_q <= cnt_n;
      commit_q <= commit_n;
      load_q <= load_n;
      snap_q <= snap_n;
    end
  end

  assign cnt_o = cnt_q;
  assign commit_o = commit_q;
  assign cmd_load_o = load_q;
  assign cmd_snap_o = snap_q;
endmodule

// File: rtl/bitser_dp.sv
module bitser_dp #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 10,
  parameter int CNT_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_bit_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              addr_shift_i,
  input  logic              data_shift_i,
  input  logic              rd_take_i,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [ADDR_W-1:0] addr_nxt_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              rd_bit_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, wdata_nxt;
  logic rd_bit_q, rd_sel, in_map;

  assign in_map = ({1'b0, addr_q} < (ADDR_W+1)'(NUM_REGS));

  always_comb begin
    addr_nxt_o = addr_q;
    for (int i = 0; i < ADDR_W; i++)
      if (cnt_i == CNT_W'(i)) addr_nxt_o[i] = wr_bit_i;
  end

  always_comb begin
    wdata_nxt = wdata_q;
    rd_sel = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (cnt_i == CNT_W'(i)) begin
        wdata_nxt[i] = wr_bit_i;
        rd_sel = reg_rdata_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wdata_q <= '0;
      rd_bit_q <= 1'b0;
    end else begin
      if (addr_shift_i) addr_q <= addr_nxt_o;
      if (data_shift_i) wdata_q <= wdata_nxt;
      if (rd_i) rd_bit_q <= rd_take_i & in_map & rd_sel;
    end
  end

  assign reg_addr_o = addr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o = commit_i & in_map;
  assign rd_bit_o = rd_bit_q;
endmodule

// File: rtl/bitser_access.sv
module bitser_access #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 10,
  parameter int CMD_LOAD = 14,
  parameter int CMD_SNAP = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wr_bit_i,
  input  logic              rd_i,
  output logic              rd_bit_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              cmd_load_o,
  output logic              cmd_snap_o
);
  localparam int MAX_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = (MAX_W > 1) ? $clog2(MAX_W) : 1;

  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] addr_nxt;
  logic addr_shift, data_shift, rd_take, commit;

  bitser_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_LOAD(CMD_LOAD),
    .CMD_SNAP(CMD_SNAP), .CNT_W(CNT_W)
  ) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_nxt_i(addr_nxt), .cnt_o(cnt), .addr_shift_o(addr_shift),
    .data_shift_o(data_shift), .rd_take_o(rd_take), .commit_o(commit),
    .cmd_load_o(cmd_load_o), .cmd_snap_o(cmd_snap_o)
  );

  bitser_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .CNT_W(CNT_W)
  ) i_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_bit_i(wr_bit_i), .rd_i(rd_i),
    .cnt_i(cnt), .addr_shift_i(addr_shift), .data_shift_i(data_shift),
    .rd_take_i(rd_take), .commit_i(commit), .reg_rdata_i(reg_rdata_i),
    .addr_nxt_o(addr_nxt), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_we_o(reg_we_o), .rd_bit_o(rd_bit_o)
  );
endmodule

// File: rtl/bitser_access_chk.sv
module bitser_access_chk #(
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic              rd_bit_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic              reg_we_o,
  input logic              cmd_load_o,
  input logic              cmd_snap_o
);
  // R7
  we_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(wr_i && !rd_i));
  // R4
  load_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_load_o |-> $past(wr_i && !rd_i));
  // R4
  snap_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_snap_o |-> $past(wr_i && !rd_i));
  // R4
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_load_o, cmd_snap_o, reg_we_o}));
  // R4
  load_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_load_o |=> !cmd_load_o);
  // R4
  snap_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_snap_o |=> !cmd_snap_o);
  // R8
  we_in_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> ({1'b0, reg_addr_o} < (ADDR_W+1)'(NUM_REGS)));
  // R11
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(reg_addr_o));
  // R6
  rdbit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_bit_o));
endmodule

bind bitser_access bitser_access_chk #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .rd_bit_o(rd_bit_o),
  .reg_addr_o(reg_addr_o), .reg_we_o(reg_we_o), .cmd_load_o(cmd_load_o),
  .cmd_snap_o(cmd_snap_o)
);

// File: tb/test_bitser_access.sv
module test_bitser_access;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_i = 1'b0, wr_bit_i = 1'b0, rd_i = 1'b0;
  logic rd_bit_o, reg_we_o, cmd_load_o, cmd_snap_o;
  logic [3:0] reg_addr_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;
  logic [7:0] mem [16];
  int checks = 0, errors = 0, we_cnt = 0, load_cnt = 0, snap_cnt = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  bitser_access i_bitser_access (.*);

  // register file model
  assign reg_rdata_i = (reg_addr_o < 4'd10) ? mem[reg_addr_o] : 8'hA5;
  always @(posedge clk_i) begin
    if (reg_we_o) begin mem[reg_addr_o] <= reg_wdata_o; we_cnt++; end
    if (cmd_load_o) load_cnt++;
    if (cmd_snap_o) snap_cnt++;
  end

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'(a * 27 + 7 + k * 64);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr_b(input logic b);
    @(negedge clk_i); wr_i = 1'b1; wr_bit_i = b;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd_b(output logic b);
    @(negedge clk_i); rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
    b = rd_bit_o;
  endtask

  task automatic send_addr(input logic [3:0] a);
    for (int i = 0; i < 4; i++) wr_b(a[i]);
  endtask

  task automatic sync8();
    logic b;
    for (int i = 0; i < 8; i++) rd_b(b);
  endtask

  task automatic write_byte(input logic [3:0] a, input logic [7:0] d, input string tag);
    int w0;
    w0 = we_cnt;
    send_addr(a);
    chk({tag, " R2 addr"}, reg_addr_o, a);
    for (int i = 0; i < 8; i++) wr_b(d[i]);
    if (a < 4'd10) begin
      chk({tag, " R7 we"}, reg_we_o, 1);
      chk({tag, " R7 wdata"}, reg_wdata_o, d);
    end else begin
      chk({tag, " R8 no we"}, reg_we_o, 0);
    end
    @(negedge clk_i);
    chk({tag, " R7 we single"}, reg_we_o, 0);
    chk({tag, " R7 we count"}, we_cnt - w0, (a < 4'd10) ? 1 : 0);
  endtask

  task automatic read_byte(input logic [3:0] a, output logic [7:0] d);
    logic b;
    send_addr(a);
    for (int i = 0; i < 8; i++) begin rd_b(b); d[i] = b; end
  endtask

  task automatic t_reset();
    chk("R1 rd_bit", rd_bit_o, 0);
    chk("R1 we", reg_we_o, 0);
    chk("R1 load", cmd_load_o, 0);
    chk("R1 snap", cmd_snap_o, 0);
    chk("R1 addr", reg_addr_o, 0);
  endtask

  task automatic t_rw_all();
    logic [7:0] d;
    for (int a = 0; a < 10; a++) write_byte(4'(a), pat(a, 0), "R5 R7 wr");
    for (int a = 0; a < 10; a++) begin
      read_byte(4'(a), d);
      chk("R6 readback", d, pat(a, 0));
    end
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    for (int a = 10; a < 14; a++) begin
      write_byte(4'(a), 8'hFF, "R8 unmapped");
      read_byte(4'(a), d);
      chk("R8 read zero", d, 0);
    end
  endtask

  task automatic t_commands();
    int l0, s0, w0;
    l0 = load_cnt; s0 = snap_cnt; w0 = we_cnt;
    send_addr(4'hE);
    chk("R4 load pulse", cmd_load_o, 1);
    chk("R4 snap quiet", cmd_snap_o, 0);
    @(negedge clk_i);
    chk("R4 load single", cmd_load_o, 0);
    send_addr(4'hF);
    chk("R4 snap pulse", cmd_snap_o, 1);
    chk("R4 load quiet", cmd_load_o, 0);
    @(negedge clk_i);
    chk("R4 snap single", cmd_snap_o, 0);
    chk("R4 load count", load_cnt - l0, 1);
    chk("R4 snap count", snap_cnt - s0, 1);
    // command returns to A0: next write goes straight to address
    write_byte(4'd6, pat(6, 1), "R4 after cmd");
    chk("R4 no stray we", we_cnt - w0, 1);
  endtask

  task automatic t_abort();
    logic b;
    logic [7:0] d;
    send_addr(4'd3);
    rd_b(b);
    wr_b(1'b1);            // opposite direction aborts
    write_byte(4'd4, pat(4, 2), "R9 after rd abort");
    read_byte(4'd3, d);
    chk("R9 addr3 intact", d, pat(3, 0));
    send_addr(4'd7);
    wr_b(1'b1); wr_b(1'b0); wr_b(1'b1);
    rd_b(b);               // aborts write phase
    chk("R9 abort read bit", b, 0);
    read_byte(4'd7, d);
    chk("R9 addr7 intact", d, pat(7, 0));
    read_byte(4'd4, d);
    chk("R9 addr4 new", d, pat(4, 2));
  endtask

  task automatic t_wait_reads();
    logic b;
    int l0;
    l0 = load_cnt;
    for (int i = 0; i < 3; i++) begin
      rd_b(b);
      chk("R3 read while idle", b, 0);
    end
    wr_b(1'b0); wr_b(1'b1);
    rd_b(b);               // discards partial address
    chk("R3 read mid addr", b, 0);
    send_addr(4'hE);
    chk("R3 R10 resync load", cmd_load_o, 1);
    @(negedge clk_i);
    chk("R3 load count", load_cnt - l0, 1);
  endtask

  task automatic t_collision();
    int l0;
    l0 = load_cnt;
    wr_b(1'b0); wr_b(1'b1);
    @(negedge clk_i); wr_i = 1'b1; rd_i = 1'b1; wr_bit_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0; rd_i = 1'b0;
    send_addr(4'hE);        // only lands on a command if collision acted as read
    @(negedge clk_i);
    chk("R12 collision as read", load_cnt - l0, 1);
  endtask

  task automatic t_idle_hold();
    logic [7:0] d;
    wr_b(1'b1); wr_b(1'b0);
    repeat (200) @(negedge clk_i);
    chk("R11 addr held", reg_addr_o[1:0], 2'b01);
    wr_b(1'b0); wr_b(1'b0);
    for (int i = 0; i < 4; i++) wr_b(1'b1);
    repeat (150) @(negedge clk_i);
    for (int i = 0; i < 4; i++) wr_b(1'b0);
    @(negedge clk_i);
    read_byte(4'd1, d);
    chk("R11 resumed write", d, 8'h0F);
  endtask

  task automatic t_recover();
    logic b;
    logic [7:0] d;
    int k = 0;
    // address phase partials
    for (int n = 1; n < 4; n++) begin
      for (int i = 0; i < n; i++) wr_b(1'b1);
      sync8();
      write_byte(4'd5, pat(5, k), "R10 rec addr");
      read_byte(4'd5, d); chk("R10 rec addr rb", d, pat(5, k)); k++;
    end
    // direction open
    send_addr(4'd2); sync8();
    write_byte(4'd5, pat(5, k), "R10 rec open");
    read_byte(4'd5, d); chk("R10 rec open rb", d, pat(5, k)); k++;
    // read partials
    for (int n = 1; n < 8; n++) begin
      send_addr(4'd2);
      for (int i = 0; i < n; i++) rd_b(b);
      sync8();
      write_byte(4'd5, pat(5, k), "R10 rec rd");
      read_byte(4'd5, d); chk("R10 rec rd rb", d, pat(5, k)); k++;
    end
    // write partials
    for (int n = 1; n < 8; n++) begin
      send_addr(4'd2);
      for (int i = 0; i < n; i++) wr_b(1'b1);
      sync8();
      write_byte(4'd5, pat(5, k), "R10 rec wr");
      read_byte(4'd5, d); chk("R10 rec wr rb", d, pat(5, k)); k++;
      read_byte(4'd2, d); chk("R9 R10 addr2 intact", d, pat(2, 0));
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_rw_all();
    t_unmapped();
    t_commands();
    t_abort();
    t_wait_reads();
    t_collision();
    t_idle_hold();
    t_recover();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule